// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits on the controller side of a two-wire serial bus. An interrupted transfer, a power loss or a reset can leave a target device holding the data line low. This block frees the bus in that case. A single-cycle request starts a recovery run. The block toggles the clock line from the system clock. Phase lengths come from cycle-count parameters. The block watches the synchronized data line near the end of every clock-high phase.

When the data line is seen released, clocking stops. The block then generates a start condition: the data line is pulled low while the clock line stays released. After the start hold time it lets the data line go again, which leaves the bus idle. If the data line is still low after the last allowed pulse, the block releases both lines and reports failure.

Both lines are modelled as pull-low enables: 1 drives the wire low and 0 releases it to the pull-up. The same parameters can give bus-rate timing at the system clock, or short phases for simulation.

Top module: `bus_recovery_seq`

## Requirements
- R1: While reset is high and after it, until a request arrives, both pull enables, `busy_o`, `done_o` and `fail_o` are 0.
- R2: If a request arrives while idle and the synchronized data line is already high, no clock pulse is issued and the start condition (R5) follows at once.
- R3: If the data line is low at the request, clock pulses are issued. Each pulse is a low phase with `scl_pull_o`=1 for exactly LOW_TICKS cycles, followed by a released high phase of exactly HIGH_TICKS cycles.
- R4: The data line passes through a two-flop synchronizer and is judged in the last cycle of each high phase. The pulse in which it is seen high is the last one issued.
- R5: The start condition works as follows. Both lines stay released for START_SU_TICKS cycles after the deciding point. Then `sda_pull_o`=1 for exactly START_HD_TICKS cycles with the clock released. Then both lines are released and `done_o` pulses for one cycle.
- R6: At most MAX_PULSES pulses are issued. If the data line is still low at the end of the last one, both lines are released, `fail_o` pulses for one cycle and no start condition is generated.
- R7: `busy_o` rises the cycle after an accepted request and falls in the cycle that `done_o` or `fail_o` is high. Requests that arrive while busy are ignored and do not restart or lengthen the run.
- R8: `sda_pull_o` is never 1 while `scl_pull_o` is 1, so the block itself never changes the data line while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_req_i | input | 1 | Single-cycle recovery request |
| sda_i | input | 1 | Sensed level of the data wire (asynchronous) |
| scl_pull_o | output | 1 | 1 pulls the clock wire low |
| sda_pull_o | output | 1 | 1 pulls the data wire low |
| busy_o | output | 1 | Recovery run in progress |
| done_o | output | 1 | One-cycle pulse: bus freed, start condition generated |
| fail_o | output | 1 | One-cycle pulse: data line still held after the last pulse |

## Verification
The checker assumes two things about the inputs. First, requests are single-cycle pulses. Second, the target releases the data line only while the clock line is low, so the line is steady by the sampling point of a high phase. The bench models a target that lets go on the K-th clock fall, so its data changes always land inside a low phase. The bench sweeps K from zero through past the pulse limit, and it injects extra requests only while a run is busy.

// File: rtl/busrec_pkg.sv
package busrec_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_SETUP,
        ST_HOLD
    } rec_state_t;

    typedef struct packed {
        logic scl_pull;
        logic sda_pull;
    } line_drive_t;

    typedef struct packed {
        logic done;
        logic fail;
    } rec_result_t;

    function automatic line_drive_t drive_for(rec_state_t s);
        line_drive_t d;
        d.scl_pull = (s == ST_LOW);
        d.sda_pull = (s == ST_HOLD);
        return d;
    endfunction

endpackage

// File: rtl/busrec_sync.sv
module busrec_sync #(
    parameter int  STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[i] <= RST_VAL;
                end else if (i == 0) begin
                    chain[i] <= d_i;
                end else begin
                    chain[i] <= chain[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/busrec_timer.sv
module busrec_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last_o = (cnt == len_i - 1'b1);
endmodule

// File: rtl/busrec_fsm.sv
module busrec_fsm
    import busrec_pkg::*;
#(
    parameter int CNT_W          = 16,
    parameter int LOW_TICKS      = 470,
    parameter int HIGH_TICKS     = 400,
    parameter int START_SU_TICKS = 470,
    parameter int START_HD_TICKS = 400,
    parameter int MAX_PULSES     = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_i,
    input  logic             sda_high_i,
    input  logic             last_i,
    output rec_state_t       state_o,
    output logic             restart_o,
    output logic [CNT_W-1:0] len_o,
    output rec_result_t      result_o
);
    localparam int PULSE_W = $clog2(MAX_PULSES + 1);
    localparam logic [PULSE_W-1:0] PULSE_LIMIT = PULSE_W'(MAX_PULSES);

    rec_state_t       state, state_n;
    rec_result_t      res_n;
    logic [PULSE_W-1:0] pulses;

    always_comb begin
        state_n = state;
        res_n   = '0;
        unique case (state)
            ST_IDLE: begin
                if (req_i) begin
                    state_n = sda_high_i ? ST_SETUP : ST_LOW;
                end
            end
            ST_LOW: begin
                if (last_i) state_n = ST_HIGH;
            end
            ST_HIGH: begin
                if (last_i) begin
                    if (sda_high_i) begin
                        state_n = ST_SETUP;
                    end else if (pulses == PULSE_LIMIT) begin
                        state_n   = ST_IDLE;
                        res_n.fail = 1'b1;
                    end else begin
                        state_n = ST_LOW;
                    end
                end
            end
            ST_SETUP: begin
                if (last_i) state_n = ST_HOLD;
            end
            ST_HOLD: begin
                if (last_i) begin
                    state_n    = ST_IDLE;
                    res_n.done = 1'b1;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (state)
            ST_LOW:   len_o = CNT_W'(LOW_TICKS);
            ST_HIGH:  len_o = CNT_W'(HIGH_TICKS);
            ST_SETUP: len_o = CNT_W'(START_SU_TICKS);
            ST_HOLD:  len_o = CNT_W'(START_HD_TICKS);
            default:  len_o = CNT_W'(1);
        endcase
    end

    assign restart_o = (state_n != state);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            pulses   <= '0;
            result_o <= '0;
        end else begin
            state    <= state_n;
            result_o <= res_n;
            if (state == ST_IDLE) begin
                pulses <= '0;
            end
            if (state_n == ST_LOW && state != ST_LOW) begin
                pulses <= ((state == ST_IDLE) ? '0 : pulses) + 1'b1;
            end
        end
    end

    assign state_o = state;
endmodule

// File: rtl/bus_recovery_seq.sv
module bus_recovery_seq
    import busrec_pkg::*;
#(
    parameter int CNT_W          = 16,
    parameter int LOW_TICKS      = 470,
    parameter int HIGH_TICKS     = 400,
    parameter int START_SU_TICKS = 470,
    parameter int START_HD_TICKS = 400,
    parameter int MAX_PULSES     = 9,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rec_req_i,
    input  logic sda_i,
    output logic scl_pull_o,
    output logic sda_pull_o,
    output logic busy_o,
    output logic done_o,
    output logic fail_o
);
    rec_state_t       state;
    rec_result_t      result;
    line_drive_t      drive;
    logic             sda_sync;
    logic             restart;
    logic             last;
    logic [CNT_W-1:0] len;

    busrec_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (sda_i),
        .q_o (sda_sync)
    );

    busrec_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .restart_i (restart),
        .len_i     (len),
        .last_o    (last)
    );

    busrec_fsm #(
        .CNT_W          (CNT_W),
        .LOW_TICKS      (LOW_TICKS),
        .HIGH_TICKS     (HIGH_TICKS),
        .START_SU_TICKS (START_SU_TICKS),
        .START_HD_TICKS (START_HD_TICKS),
        .MAX_PULSES     (MAX_PULSES)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_i      (rec_req_i),
        .sda_high_i (sda_sync),
        .last_i     (last),
        .state_o    (state),
        .restart_o  (restart),
        .len_o      (len),
        .result_o   (result)
    );

    assign drive      = drive_for(state);
    assign scl_pull_o = drive.scl_pull;
    assign sda_pull_o = drive.sda_pull;
    assign busy_o     = (state != ST_IDLE);
    assign done_o     = result.done;
    assign fail_o     = result.fail;
endmodule

// File: rtl/busrec_checker.sv
module busrec_checker #(
    parameter int LOW_TICKS  = 470,
    parameter int MAX_PULSES = 9
) (
    input logic clk,
    input logic rst,
    input logic rec_req_i,
    input logic scl_pull_o,
    input logic sda_pull_o,
    input logic busy_o,
    input logic done_o,
    input logic fail_o
);
    int   low_run;
    int   pulse_cnt;
    logic scl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run   <= 0;
            pulse_cnt <= 0;
            scl_q     <= 1'b0;
        end else begin
            scl_q   <= scl_pull_o;
            low_run <= scl_pull_o ? low_run + 1 : 0;
            if (!busy_o) begin
                pulse_cnt <= 0;
            end else if (scl_pull_o && !scl_q) begin
                pulse_cnt <= pulse_cnt + 1;
            end
        end
    end

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!scl_pull_o && !sda_pull_o)); // R1

    AST_LOW_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $fell(scl_pull_o) |-> (low_run == LOW_TICKS)); // R3

    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(sda_pull_o)); // R5

    AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (rst)
        pulse_cnt <= MAX_PULSES); // R6

    AST_FAIL_NO_START: assert property (@(posedge clk) disable iff (rst)
        fail_o |-> !$past(sda_pull_o)); // R6

    AST_REQ_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (rec_req_i && !busy_o) |=> busy_o); // R7

    AST_BUSY_END: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (done_o || fail_o)); // R7

    AST_SDA_UNDER_SCL: assert property (@(posedge clk) disable iff (rst)
        sda_pull_o |-> !scl_pull_o); // R8
endmodule

bind bus_recovery_seq busrec_checker #(
    .LOW_TICKS  (LOW_TICKS),
    .MAX_PULSES (MAX_PULSES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rec_req_i  (rec_req_i),
    .scl_pull_o (scl_pull_o),
    .sda_pull_o (sda_pull_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .fail_o     (fail_o)
);

// File: tb/bus_recovery_seq_bench.sv
module bus_recovery_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int L   = 4;
    localparam int H   = 3;
    localparam int SU  = 5;
    localparam int HD  = 3;
    localparam int MAXP = 9;
    localparam int WATCHDOG = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0;
    logic scl_pull, sda_pull, busy, done, fail;
    logic hold = 1'b0;
    logic sda_line;

    int checks = 0;
    int fails  = 0;
    int k_target = 0;
    logic arm = 1'b0;

    int pulses, busy_cyc, low_bad, high_bad, setup_len, hold_len;
    int starts, done_cnt, fail_cnt, overlap, lrun, hrun, rel_run;
    logic prev_scl = 1'b0, prev_sda = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line = !(sda_pull | hold);

    bus_recovery_seq #(
        .CNT_W(8), .LOW_TICKS(L), .HIGH_TICKS(H),
        .START_SU_TICKS(SU), .START_HD_TICKS(HD), .MAX_PULSES(MAXP)
    ) u_bus_recovery_seq (
        .clk(clk), .rst(rst), .rec_req_i(req), .sda_i(sda_line),
        .scl_pull_o(scl_pull), .sda_pull_o(sda_pull),
        .busy_o(busy), .done_o(done), .fail_o(fail)
    );

    // Monitor and target model, evaluated away from the active edge
    always @(negedge clk) begin
        if (arm) begin
            pulses = 0; busy_cyc = 0; low_bad = 0; high_bad = 0;
            setup_len = -1; hold_len = 0; starts = 0; done_cnt = 0;
            fail_cnt = 0; overlap = 0; lrun = 0; hrun = 0; rel_run = 0;
            hold = (k_target != 0);
        end else begin
            if (busy) busy_cyc++;
            if (done) done_cnt++;
            if (fail) fail_cnt++;
            if (scl_pull && sda_pull) overlap++;
            if (scl_pull && !prev_scl) begin
                if (pulses > 0 && hrun != H) high_bad++;
                pulses++;
                if (pulses == k_target) hold = 1'b0;
            end
            if (!scl_pull && prev_scl && lrun != L) low_bad++;
            lrun = scl_pull ? lrun + 1 : 0;
            hrun = (busy && !scl_pull) ? hrun + 1 : 0;
            if (sda_pull && !prev_sda) begin
                starts++;
                setup_len = rel_run;
            end
            if (sda_pull) hold_len++;
            rel_run = (busy && !scl_pull && !sda_pull) ? rel_run + 1 : 0;
        end
        prev_scl = scl_pull;
        prev_sda = sda_pull;
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic run_case(input int k, input bit inject);
        bit exp_done;
        int exp_p, exp_busy;
        @(negedge clk); #1;
        k_target = k; arm = 1'b1;
        @(negedge clk); #1;
        arm = 1'b0;
        repeat (4) @(negedge clk);
        #1 req = 1'b1;
        @(negedge clk); #1 req = 1'b0;
        if (inject) begin
            repeat (10) @(negedge clk);
            #1 req = 1'b1;
            @(negedge clk); #1 req = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);

        exp_done = (k <= MAXP);
        exp_p    = exp_done ? k : MAXP;
        exp_busy = exp_done ? k*(L+H) + SU + HD : MAXP*(L+H);
        chk(done_cnt == int'(exp_done), "R5 done count", done_cnt, int'(exp_done));
        chk(fail_cnt == int'(!exp_done), "R6 fail count", fail_cnt, int'(!exp_done));
        chk(pulses == exp_p, "R4 pulse count", pulses, exp_p);
        chk(busy_cyc == exp_busy, "R7 busy cycles", busy_cyc, exp_busy);
        chk(low_bad == 0, "R3 low phase width", low_bad, 0);
        chk(high_bad == 0, "R3 high phase width", high_bad, 0);
        chk(overlap == 0, "R8 data pulled under low clock", overlap, 0);
        chk(!scl_pull && !sda_pull && !busy, "R6 lines released at end",
            int'({scl_pull, sda_pull, busy}), 0);
        if (exp_done) begin
            chk(starts == 1, "R5 start count", starts, 1);
            chk(setup_len == ((k == 0) ? SU : H + SU),
                (k == 0) ? "R2 direct start setup" : "R5 start setup",
                setup_len, (k == 0) ? SU : H + SU);
            chk(hold_len == HD, "R5 start hold", hold_len, HD);
        end else begin
            chk(starts == 0, "R6 no start on fail", starts, 0);
        end
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(!scl_pull && !sda_pull && !busy && !done && !fail, "R1 in reset",
            int'({scl_pull, sda_pull, busy, done, fail}), 0);
        #1 rst = 1'b0;
        repeat (5) @(negedge clk);
        chk(!scl_pull && !sda_pull && !busy && !done && !fail, "R1 after reset",
            int'({scl_pull, sda_pull, busy, done, fail}), 0);
        for (int k = 0; k <= MAXP + 2; k++) begin
            run_case(k, 1'b0);
        end
        // R7: extra requests while busy must not restart or stretch the run
        run_case(3, 1'b1);
        run_case(6, 1'b1);
        run_case(MAXP + 1, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule